// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Mirror

This block keeps the interrupt-related configuration bytes of a two-channel storage controller and drives one level-sensitive interrupt line. Each channel raises a request input. A change on that input sets or clears the channel's status bit. The status of each channel can be seen, and cleared, at two places in configuration space: a summary byte that also carries the per-channel block bits, and a legacy mirror byte for that channel. The two copies always agree. Writing a one to either copy clears both copies.

Software reaches the bytes through a dword-addressed configuration port. The port has 32-bit write data, four byte enables and combinational read data for the dword currently addressed. Status bits can only be cleared by a write, never set. The block bits in the summary byte are ordinary read/write bits. The interrupt output combines the status and block bits of both channels.

Top module: `irq_status_mirror`

## Requirements
- R1: Reset clears every status and block bit. While reset is held and after it is released, with no other stimulus, `irqOut` is 0 and all reads return 0.
- R2: A rising edge on `chReq[n]` sets the status of channel n. The new status is visible after the clock edge at which the rise is sampled. Channel 0 status reads at byte 0x71 bit 2, which is dword 0x1C data bit 10, and also at byte 0x50 bit 2, which is dword 0x14 data bit 2. Channel 1 status reads at byte 0x71 bit 3, which is dword 0x1C data bit 11, and also at byte 0x57 bit 4, which is dword 0x15 data bit 28.
- R3: A falling edge on `chReq[n]` clears the status of channel n in both places.
- R4: Writing a one to byte 0x71 bit 2 or bit 3 clears the status of the matching channel. Writing a zero to either bit leaves it unchanged.
- R5: Writing a one to byte 0x50 bit 2 clears channel 0 status. Writing a one to byte 0x57 bit 4 clears channel 1 status. In both cases the summary copy clears as well.
- R6: No write can set a status bit.
- R7: Byte 0x71 bit 4 blocks channel 0 and bit 5 blocks channel 1. These are dword 0x1C data bits 12 and 13. A write with lane 1 enabled loads both bits, and reads return them.
- R8: `irqOut` is 1 exactly when channel 0 status is set and not blocked, or channel 1 status is set and not blocked. It follows every write or request edge on the clock edge that applies it.
- R9: If a request rise and a clearing write to the same channel arrive in the same cycle, the status ends up set.
- R10: Byte address A maps to dword A/4 and byte lane A mod 4. Lane n is data bits 8n+7 down to 8n. A write affects a byte only when `cfgWrEn` is 1, `cfgAddr` matches that dword and the lane's enable bit is set. All bits not named above read as 0.
- R11: A request held high after its status has been cleared does not set the status again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chReq | input | 2 | Per-channel interrupt request levels |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Dword index into configuration space |
| cfgByteEn | input | 4 | Byte lane enables for writes |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for the dword at `cfgAddr` |
| irqOut | output | 1 | Combined level interrupt |

## Verification
The directed patterns raise and drop each request on its own and both together, then clear each channel through the summary byte and through its own mirror byte. The mirror-byte clears show whether the two copies really share one state. Writes with the wrong lane enabled, to the wrong dword, or with zeros and ones in status positions that are already clear separate true write-one-to-clear behaviour from plain stores and from loose address decoding. A same-cycle rise and clear, a request held high after a clear, and block-bit toggling while both channels are pending expose priority mistakes and gating mistakes. A long stretch of random request, address and lane patterns is then compared against the reference model on every clock.

// File: rtl/irq_status_mirror_pkg.sv
package irq_status_mirror_pkg;
  parameter int NUM_CH = 2;
  parameter int ADDR_W = 6;
  parameter int DATA_W = 32;
  localparam int LANES = DATA_W / 8;

  // byte offsets whose bit positions a driver decodes
  localparam logic [7:0] SUM_OFS  = 8'h71;
  localparam logic [7:0] MIRA_OFS = 8'h50;
  localparam logic [7:0] MIRB_OFS = 8'h57;
  localparam int SUM_ST_BIT  = 2;  // ch0 status, ch1 at +1
  localparam int SUM_BLK_BIT = 4;  // ch0 block, ch1 at +1
  localparam int MIRA_BIT    = 2;
  localparam int MIRB_BIT    = 4;

  typedef struct packed {
    logic [NUM_CH-1:0] setSt;
    logic [NUM_CH-1:0] dropSt;
    logic [NUM_CH-1:0] clrSt;
    logic              blkWe;
    logic [NUM_CH-1:0] blkVal;
  } strobe_t;
endpackage

// File: rtl/irq_status_mirror_ctrl.sv
module irq_status_mirror_ctrl
  import irq_status_mirror_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   chReq,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [LANES-1:0]    cfgByteEn,
  input  logic [DATA_W-1:0]   cfgWrData,
  output strobe_t             strb
);
  localparam int SUM_LANE  = int'(SUM_OFS[1:0]);
  localparam int MIRA_LANE = int'(MIRA_OFS[1:0]);
  localparam int MIRB_LANE = int'(MIRB_OFS[1:0]);
  localparam logic [ADDR_W-1:0] SUM_DW  = ADDR_W'(SUM_OFS[7:2]);
  localparam logic [ADDR_W-1:0] MIRA_DW = ADDR_W'(MIRA_OFS[7:2]);
  localparam logic [ADDR_W-1:0] MIRB_DW = ADDR_W'(MIRB_OFS[7:2]);

  logic [NUM_CH-1:0] reqPrev;
  logic hitSum, hitMirA, hitMirB;
  logic [7:0] sumByte, mirAByte, mirBByte;

  always_ff @(posedge clk) begin
    if (!rstN) reqPrev <= '0;
    else       reqPrev <= chReq;
  end

  always_comb begin
    hitSum   = cfgWrEn && (cfgAddr == SUM_DW)  && cfgByteEn[SUM_LANE];
    hitMirA  = cfgWrEn && (cfgAddr == MIRA_DW) && cfgByteEn[MIRA_LANE];
    hitMirB  = cfgWrEn && (cfgAddr == MIRB_DW) && cfgByteEn[MIRB_LANE];
    sumByte  = cfgWrData[8*SUM_LANE +: 8];
    mirAByte = cfgWrData[8*MIRA_LANE +: 8];
    mirBByte = cfgWrData[8*MIRB_LANE +: 8];

    strb.setSt  = chReq & ~reqPrev;
    strb.dropSt = ~chReq & reqPrev;
    strb.clrSt[0] = (hitSum && sumByte[SUM_ST_BIT]) || (hitMirA && mirAByte[MIRA_BIT]);
    strb.clrSt[1] = (hitSum && sumByte[SUM_ST_BIT+1]) || (hitMirB && mirBByte[MIRB_BIT]);
    strb.blkWe  = hitSum;
    strb.blkVal = sumByte[SUM_BLK_BIT +: NUM_CH];
  end

  // R10
  no_clr_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |-> (strb.clrSt == '0 && !strb.blkWe));
  // R2
  rise_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setSt != '0) |=> ((reqPrev & $past(strb.setSt)) == $past(strb.setSt)));
endmodule

// File: rtl/irq_status_mirror_dp.sv
module irq_status_mirror_dp
  import irq_status_mirror_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] cfgAddr,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] SUM_DW  = ADDR_W'(SUM_OFS[7:2]);
  localparam logic [ADDR_W-1:0] MIRA_DW = ADDR_W'(MIRA_OFS[7:2]);
  localparam logic [ADDR_W-1:0] MIRB_DW = ADDR_W'(MIRB_OFS[7:2]);
  localparam int SUM_POS  = 8*int'(SUM_OFS[1:0]);
  localparam int MIRA_POS = 8*int'(MIRA_OFS[1:0]);
  localparam int MIRB_POS = 8*int'(MIRB_OFS[1:0]);

  logic [NUM_CH-1:0] stat;
  logic [NUM_CH-1:0] blk;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN)                   stat[ch] <= 1'b0;
      else if (strb.setSt[ch])     stat[ch] <= 1'b1;  // request wins
      else if (strb.dropSt[ch])    stat[ch] <= 1'b0;
      else if (strb.clrSt[ch])     stat[ch] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)            blk[ch] <= 1'b0;
      else if (strb.blkWe)  blk[ch] <= strb.blkVal[ch];
    end

    // R2
    set_applies_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.setSt[ch] |=> stat[ch]);
    // R3
    drop_applies_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.dropSt[ch] |=> !stat[ch]);
    // R6
    no_write_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.setSt[ch] && !stat[ch]) |=> !stat[ch]);
    // R9
    req_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.setSt[ch] && strb.clrSt[ch]) |=> stat[ch]);
  end

  always_comb begin
    cfgRdData = '0;
    unique case (cfgAddr)
      SUM_DW: begin
        cfgRdData[SUM_POS + SUM_ST_BIT  +: NUM_CH] = stat;
        cfgRdData[SUM_POS + SUM_BLK_BIT +: NUM_CH] = blk;
      end
      MIRA_DW: cfgRdData[MIRA_POS + MIRA_BIT] = stat[0];
      MIRB_DW: cfgRdData[MIRB_POS + MIRB_BIT] = stat[1];
      default: cfgRdData = '0;
    endcase
  end

  assign irqOut = |(stat & ~blk);

  // R8
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (stat != '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (!irqOut && stat == '0 && blk == '0));
endmodule

// File: rtl/irq_status_mirror.sv
module irq_status_mirror
  import irq_status_mirror_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  chReq,
  input  logic        cfgWrEn,
  input  logic [5:0]  cfgAddr,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  output logic        irqOut
);
  strobe_t strb;

  irq_status_mirror_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chReq(chReq), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .strb(strb)
  );

  irq_status_mirror_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgAddr(cfgAddr),
    .cfgRdData(cfgRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/irq_status_mirror_tb.sv
module irq_status_mirror_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  chReq = '0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        irqOut;

  int vectors = 0;
  int miscompares = 0;
  int mSt[2];
  int mBlk[2];
  int mPrv[2];

  always #10 clk = ~clk;  // 50 MHz

  irq_status_mirror u_dut (
    .clk(clk), .rstN(rstN), .chReq(chReq), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] expRead(input logic [5:0] a);
    logic [31:0] v = '0;
    if (a == 6'h1C) begin
      v[10] = mSt[0][0]; v[11] = mSt[1][0];
      v[12] = mBlk[0][0]; v[13] = mBlk[1][0];
    end else if (a == 6'h14) v[2] = mSt[0][0];
    else if (a == 6'h15) v[28] = mSt[1][0];
    return v;
  endfunction

  task automatic step(input logic [1:0] req, input logic we, input logic [5:0] a,
                      input logic [3:0] be, input logic [31:0] d, input string tag);
    logic [31:0] expD;
    int expIrq;
    @(negedge clk);
    chReq = req; cfgWrEn = we; cfgAddr = a; cfgByteEn = be; cfgWrData = d;
    @(posedge clk);
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin mSt[c] = 0; mBlk[c] = 0; mPrv[c] = 0; end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int clr = 0;
        if (we && a == 6'h1C && be[1] && d[10+c]) clr = 1;
        if (c == 0 && we && a == 6'h14 && be[0] && d[2]) clr = 1;
        if (c == 1 && we && a == 6'h15 && be[3] && d[28]) clr = 1;
        if (req[c] && mPrv[c] == 0) mSt[c] = 1;
        else if (!req[c] && mPrv[c] == 1) mSt[c] = 0;
        else if (clr != 0) mSt[c] = 0;
        mPrv[c] = req[c];
      end
      if (we && a == 6'h1C && be[1]) begin mBlk[0] = d[12]; mBlk[1] = d[13]; end
    end
    #1;
    expD = expRead(a);
    expIrq = ((mSt[0] != 0 && mBlk[0] == 0) || (mSt[1] != 0 && mBlk[1] == 0)) ? 1 : 0;
    vectors++;
    if (cfgRdData !== expD) begin
      miscompares++;
      $display("FAIL %s rdData addr=%h actual=%h expected=%h", tag, a, cfgRdData, expD);
    end
    if (irqOut !== expIrq[0]) begin
      miscompares++;
      $display("FAIL %s irqOut actual=%0b expected=%0d", tag, irqOut, expIrq);
    end
  endtask

  initial begin
    #3_000_000;
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: held in reset, then released idle
    step(2'b00, 0, 6'h1C, 4'h0, 0, "R1");
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R1");
    step(2'b00, 0, 6'h14, 4'h0, 0, "R1");
    rstN = 1'b1;
    step(2'b00, 0, 6'h1C, 4'h0, 0, "R1");
    step(2'b00, 0, 6'h15, 4'h0, 0, "R1");
    // R2 / R8: rises set status, seen at both copies
    step(2'b01, 0, 6'h1C, 4'h0, 0, "R2");
    step(2'b01, 0, 6'h14, 4'h0, 0, "R2");
    step(2'b11, 0, 6'h15, 4'h0, 0, "R2");
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R8");
    // R7: block channel 0, ch1 still drives irq
    step(2'b11, 1, 6'h1C, 4'b0010, 32'h0000_1000, "R7");
    // R5: clear ch1 via its mirror, irq drops as ch0 blocked
    step(2'b11, 1, 6'h15, 4'b1000, 32'h1000_0000, "R5");
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R5");
    // R7 / R4: unblock; zeros in status bits change nothing
    step(2'b11, 1, 6'h1C, 4'b0010, 32'h0, "R7");
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R4");
    // R10: wrong lane, wrong dword
    step(2'b11, 1, 6'h1C, 4'b1101, 32'hFFFF_FFFF, "R10");
    step(2'b11, 1, 6'h1D, 4'b1111, 32'hFFFF_FFFF, "R10");
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R10");
    step(2'b11, 0, 6'h3F, 4'h0, 0, "R10");
    // R4: clear ch0 via summary; R11: held request stays cleared
    step(2'b11, 1, 6'h1C, 4'b0010, 32'h0000_0400, "R4");
    step(2'b11, 0, 6'h14, 4'h0, 0, "R11");
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R11");
    // R6: ones to clear bits do not set them
    step(2'b11, 1, 6'h1C, 4'b0010, 32'h0000_0C00, "R6");
    step(2'b11, 1, 6'h14, 4'b0001, 32'h0000_0004, "R6");
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R6");
    // R3: fall then rise then fall
    step(2'b10, 0, 6'h1C, 4'h0, 0, "R3");
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R3");
    step(2'b10, 0, 6'h14, 4'h0, 0, "R3");
    step(2'b00, 0, 6'h15, 4'h0, 0, "R3");
    // R9: rise and clear same cycle
    step(2'b10, 1, 6'h15, 4'b1000, 32'h1000_0000, "R9");
    step(2'b10, 0, 6'h1C, 4'h0, 0, "R9");
    // R5: ch0 mirror clear also clears summary copy
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R5");
    step(2'b11, 1, 6'h14, 4'b0001, 32'h0000_0004, "R5");
    step(2'b11, 0, 6'h1C, 4'h0, 0, "R5");
    // R8: both blocked, both pending
    step(2'b00, 0, 6'h1C, 4'h0, 0, "R8");
    step(2'b11, 1, 6'h1C, 4'b0010, 32'h0000_3000, "R8");
    step(2'b11, 1, 6'h1C, 4'b0010, 32'h0000_2000, "R8");
    // random mix, R8
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] a;
      case ($urandom % 4)
        0: a = 6'h14;
        1: a = 6'h15;
        2: a = 6'h1C;
        default: a = 6'h1D;
      endcase
      step(2'($urandom), 1'($urandom), a, 4'($urandom), $urandom, "R8");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule